// File: doc/BRIEF.md
# Microcontroller GPIO Port with Tristate Control

This block is a six-pin general-purpose I/O port for a small microcontroller core. Each pin has a bit in an output data latch and a bit in a direction register. The direction register cannot be read back. It is loaded only by a dedicated strobe that copies the accumulator value presented on the write-data bus. A plain port write loads the output latch. When a pin's direction bit is 0, the pin drives its latch value. When the bit is 1, the pin's driver is off (high impedance).

Reads of the port return the pin levels, after they pass through a synchroniser. They never return the latch. The CPU's bit-set and bit-clear operations are done as read-modify-write. The unit takes the synchronised pin levels, changes the selected bit and writes the whole word back into the latch. As a result, a pin that is currently an input has its latch overwritten with whatever level is on the pin.

Pin 3 is input-only and never drives. An external option control can take pin 2 over and force its driver off, whatever its direction bit says.

Top module: `gpio_port_tri`

## Requirements
- R1: After a synchronous reset, every direction bit is 1, so `pin_oe` is 0x00. `pin_out` (the latch) is 0x00 and `rd_data` is 0x00.
- R2: A `dir_load` pulse copies `wr_data[5:0]` into the direction register. Two rising edges after that pulse, `pin_oe[i]` equals the inverse of direction bit i for every pin except 3, and for pin 2 only while `ovr_en` is 0.
- R3: A `port_wr` pulse copies `wr_data[5:0]` into the latch for all six pins, whatever their direction. `pin_out` shows the latch on the next edge.
- R4: `rd_data[5:0]` reports the synchronised pin levels and not the latch. `rd_data[7:6]` always reads 0.
- R5: A change on `pin_in` first appears on `rd_data` at the third rising edge after it: two synchroniser stages, then the read register.
- R6: A `bit_op` pulse with `bit_sel` below 6 loads the latch with the synchronised pins, with bit `bit_sel` replaced by `bit_set`. A `bit_set` of 1 sets the bit and 0 clears it.
- R7: During a bit operation, a pin in input mode gets its latch bit overwritten with the level on that pin.
- R8: `pin_oe[3]` is always 0, whatever the direction register holds.
- R9: While `ovr_en` is 1, `pin_oe[2]` is 0 from the next edge on, regardless of direction bit 2.
- R10: A `bit_op` with `bit_sel` of 6 or 7 still rewrites the latch with the synchronised pins, but changes no bit.
- R11: When `port_wr` and `bit_op` are both asserted in the same cycle, the plain write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 8 | Accumulator / write data |
| port_wr | input | 1 | Load output latch from `wr_data` |
| dir_load | input | 1 | Load direction register from `wr_data` |
| bit_op | input | 1 | Start a read-modify-write bit operation |
| bit_set | input | 1 | Bit value for the operation (1 set, 0 clear) |
| bit_sel | input | 3 | Bit index for the operation |
| ovr_en | input | 1 | Option control that forces pin 2's driver off |
| pin_in | input | 6 | Levels sensed at the pins |
| pin_out | output | 6 | Drive value (latch contents) |
| pin_oe | output | 6 | Driver enable, 1 = driving |
| rd_data | output | 8 | Port read value |

## Verification
The bench builds the block with its default parameters: six pins, an eight-bit bus, two synchroniser stages, pin 3 input-only and pin 2 overridable. With that small configuration, all 64 direction words can be swept with the option control both off and on. Every bit index, including the two unimplemented ones, can be combined with both set and clear over several pin patterns. The bench computes the expected latch arithmetically from the pin pattern, index and value, and checks the three-edge read latency edge by edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Replace one bit of a word when the index is in range.
  function automatic logic [7:0] put_bit(input logic [7:0] word, input logic [2:0] idx,
                                         input logic val, input int width);
    logic [7:0] r;
    r = word;
    for (int i = 0; i < 8; i++) begin
      if (i < width && idx == 3'(i)) r[i] = val;
    end
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int W        = 6,
  parameter int BUS_W    = 8,
  parameter int IN_ONLY  = 3,
  parameter int OVR_PIN  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BUS_W-1:0] acc,
  input  logic             ovr_en,
  output logic [W-1:0]     oe
);
  logic [W-1:0] dir_q;

  always_ff @(posedge clk) begin
    if (rst) dir_q <= '1;
    else if (load) dir_q <= acc[W-1:0];
  end

  for (genvar i = 0; i < W; i++) begin : g_oe
    always_ff @(posedge clk) begin
      if (rst) oe[i] <= 1'b0;
      else if (i == IN_ONLY) oe[i] <= 1'b0;
      else if (i == OVR_PIN) oe[i] <= ~dir_q[i] & ~ovr_en;
      else oe[i] <= ~dir_q[i];
    end
  end
endmodule

// File: rtl/gpio_latch.sv
module gpio_latch
  import gpio_port_pkg::*;
#(
  parameter int W     = 6,
  parameter int BUS_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             bop,
  input  logic             bval,
  input  logic [SEL_W-1:0] bsel,
  input  logic [W-1:0]     pins,
  output logic [W-1:0]     latch
);
  logic [7:0] merged;

  always_comb begin
    merged = put_bit(8'(pins), 3'(bsel), bval, W);
  end

  always_ff @(posedge clk) begin
    if (rst) latch <= '0;
    else if (wr) latch <= wdata[W-1:0];
    else if (bop) latch <= merged[W-1:0];
  end
endmodule

// File: rtl/gpio_port_tri.sv
module gpio_port_tri #(
  parameter int PORT_W  = 6,
  parameter int BUS_W   = 8,
  parameter int STAGES  = 2,
  parameter int IN_ONLY = 3,
  parameter int OVR_PIN = 2,
  localparam int SEL_W  = $clog2(BUS_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              port_wr,
  input  logic              dir_load,
  input  logic              bit_op,
  input  logic              bit_set,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              ovr_en,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [BUS_W-1:0]  rd_data
);
  logic [PORT_W-1:0] pin_s;

  gpio_sync #(.W(PORT_W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s));

  gpio_dir_reg #(.W(PORT_W), .BUS_W(BUS_W), .IN_ONLY(IN_ONLY), .OVR_PIN(OVR_PIN)) u_dir (
    .clk(clk), .rst(rst), .load(dir_load), .acc(wr_data), .ovr_en(ovr_en), .oe(pin_oe));

  gpio_latch #(.W(PORT_W), .BUS_W(BUS_W), .SEL_W(SEL_W)) u_lat (
    .clk(clk), .rst(rst), .wr(port_wr), .wdata(wr_data), .bop(bit_op), .bval(bit_set),
    .bsel(bit_sel), .pins(pin_s), .latch(pin_out));

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else rd_data <= BUS_W'(pin_s);
  end
endmodule

// File: rtl/gpio_port_tri_chk.sv
module gpio_port_tri_chk #(
  parameter int PORT_W  = 6,
  parameter int BUS_W   = 8,
  parameter int IN_ONLY = 3,
  parameter int OVR_PIN = 2,
  parameter int SEL_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_W-1:0]  wr_data,
  input logic              port_wr,
  input logic              bit_op,
  input logic              bit_set,
  input logic [SEL_W-1:0]  bit_sel,
  input logic              ovr_en,
  input logic [PORT_W-1:0] pin_in,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [BUS_W-1:0]  rd_data
);
  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && rd_data == '0));
  assert_latch_wr_R3: assert property (@(posedge clk) disable iff (rst)
    port_wr |=> pin_out == $past(wr_data[PORT_W-1:0]));
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rd_data[BUS_W-1:PORT_W] == '0);
  assert_read_lat_R5: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd3) |-> rd_data[PORT_W-1:0] == $past(pin_in, 3));
  assert_bitop_R6: assert property (@(posedge clk) disable iff (rst)
    (bit_op && !port_wr && bit_sel < SEL_W'(PORT_W)) |=> pin_out[$past(bit_sel)] == $past(bit_set));
  assert_in_only_R8: assert property (@(posedge clk) disable iff (rst)
    !pin_oe[IN_ONLY]);
  assert_override_R9: assert property (@(posedge clk) disable iff (rst)
    ovr_en |=> !pin_oe[OVR_PIN]);
endmodule

bind gpio_port_tri gpio_port_tri_chk #(
  .PORT_W(PORT_W), .BUS_W(BUS_W), .IN_ONLY(IN_ONLY), .OVR_PIN(OVR_PIN), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_data(wr_data), .port_wr(port_wr), .bit_op(bit_op),
  .bit_set(bit_set), .bit_sel(bit_sel), .ovr_en(ovr_en), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .rd_data(rd_data));

// File: tb/gpio_port_tri_bench.sv
module gpio_port_tri_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wr_data = '0;
  logic       port_wr = 1'b0, dir_load = 1'b0, bit_op = 1'b0, bit_set = 1'b0, ovr_en = 1'b0;
  logic [2:0] bit_sel = '0;
  logic [5:0] pin_in = '0;
  logic [5:0] pin_out, pin_oe;
  logic [7:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_tri u_gpio_port_tri (
    .clk(clk), .rst(rst), .wr_data(wr_data), .port_wr(port_wr), .dir_load(dir_load),
    .bit_op(bit_op), .bit_set(bit_set), .bit_sel(bit_sel), .ovr_en(ovr_en),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .rd_data(rd_data));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_dir(input logic [7:0] v);
    wr_data = v; dir_load = 1'b1; cyc(1); dir_load = 1'b0;
  endtask

  task automatic write_port(input logic [7:0] v);
    wr_data = v; port_wr = 1'b1; cyc(1); port_wr = 1'b0;
  endtask

  task automatic do_bit(input logic [2:0] s, input logic v);
    bit_sel = s; bit_set = v; bit_op = 1'b1; cyc(1); bit_op = 1'b0;
  endtask

  function automatic logic [5:0] oe_exp(input logic [5:0] d, input logic ov);
    logic [5:0] e;
    e = ~d;
    e[3] = 1'b0;
    if (ov) e[2] = 1'b0;
    return e;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] pats [4];
    pats[0] = 6'h2A; pats[1] = 6'h15; pats[2] = 6'h3F; pats[3] = 6'h00;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    check("R1 oe", 8'(pin_oe), 8'h00);
    check("R1 latch", 8'(pin_out), 8'h00);
    check("R1 rd", rd_data, 8'h00);

    // R2, R8, R9 sweep of all direction words with the override off and on
    for (int ov = 0; ov < 2; ov++) begin
      ovr_en = ov[0];
      for (int d = 0; d < 64; d++) begin
        load_dir(8'(d) | 8'hC0);
        cyc(1);
        check(ov ? "R9 oe sweep" : "R2 oe sweep", 8'(pin_oe), 8'(oe_exp(6'(d), ov[0])));
        check("R8 pin3", {7'b0, pin_oe[3]}, 8'h00);
      end
    end
    ovr_en = 1'b0;

    // R3 plain write ignores direction (all pins inputs)
    load_dir(8'hFF);
    write_port(8'hE5);
    check("R3 latch", 8'(pin_out), 8'h25);

    // R4 read returns pins, not latch
    load_dir(8'h00);
    write_port(8'h3F);
    pin_in = 6'h00;
    cyc(4);
    check("R4 pins not latch", rd_data, 8'h00);
    pin_in = 6'h3F;
    cyc(4);
    check("R4 upper zero", rd_data, 8'h3F);

    // R5 latency: old after two edges, new after the third
    pin_in = 6'h00; cyc(4);
    pin_in = 6'h2D;
    cyc(2);
    check("R5 before", rd_data, 8'h00);
    cyc(1);
    check("R5 after", rd_data, 8'h2D);

    // R6, R10 sweep over indices, values and pin patterns
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 8; s++) begin
        for (int v = 0; v < 2; v++) begin
          logic [5:0] e;
          write_port(8'(~pats[p]));
          pin_in = pats[p];
          cyc(3);
          do_bit(3'(s), v[0]);
          e = pats[p];
          if (s < 6) e[s] = v[0];
          check(s < 6 ? "R6 bit op" : "R10 high index", 8'(pin_out), 8'(e));
        end
      end
    end

    // R7 input-mode pins pick up pin levels
    load_dir(8'hFF);
    write_port(8'h00);
    pin_in = 6'h3F;
    cyc(3);
    do_bit(3'd0, 1'b0);
    check("R7 input pins rewritten", 8'(pin_out), 8'h3E);

    // R11 plain write wins over a simultaneous bit op
    wr_data = 8'h09; port_wr = 1'b1; bit_op = 1'b1; bit_sel = 3'd1; bit_set = 1'b1;
    cyc(1);
    port_wr = 1'b0; bit_op = 1'b0;
    check("R11 write priority", 8'(pin_out), 8'h09);

    // R9 override removes pin 2 drive, then releases it
    load_dir(8'h00);
    cyc(1);
    check("R9 released", 8'(pin_oe), 8'h37);
    ovr_en = 1'b1; cyc(1);
    check("R9 forced", 8'(pin_oe), 8'h33);
    ovr_en = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule